// File: doc/BRIEF.md
# Programmable Rate Generator Counter

This block is one down-counter channel that turns its input clock into a periodic strobe. A host programs it through a byte-wide write port that has two targets. The control target takes a setup word. The data target takes the 16-bit divisor as two byte writes, low byte first and high byte second. Once the divisor is complete, the channel counts down in binary. Its output stays high through each period and drops for a single clock when the count reaches 1. The counter then reloads itself, so the output repeats every N clocks, where N is the programmed divisor.

The channel responds only to setup words that carry its own channel number, request low-then-high byte access, select the rate-generator mode and select binary counting. Every other setup word leaves the channel untouched. A new divisor written while the channel is running is held back until the current period ends. A new setup word, by contrast, stops the channel at once.

Top module: `rg_timer`

## Requirements
- R1: After reset the output is high and the counter is idle. Data writes are ignored until a valid setup word has been accepted, and the output stays high while they are ignored.
- R2: A write with `wr_ctrl`=1 is a setup word. Bit 0 selects BCD and must be 0. Bits 3:1 select the mode, and the channel accepts only 010 or 110, both meaning rate generator. Bits 5:4 select the access order and must be 11, low then high. Bits 7:6 carry the channel number and must equal `CHAN_SEL`. Examples for channel 0 are 0x34 and 0x3C.
- R3: A setup word that fails any test in R2 is ignored. This covers a different channel number, an access order other than 11, another mode, or BCD. An ignored word leaves the running count, the output and the byte pointer unchanged.
- R4: A write with `wr_ctrl`=0 is a data write. The first data write after an accepted setup word is the low byte and the second is the high byte. The byte pointer holds its state through any number of idle cycles between the two writes.
- R5: Counting begins on the edge that captures the high byte. The output is low for exactly one clock, in the cycle that follows the (N-1)th clock edge after that capture, and then low again every N clocks. It is high at all other times.
- R6: A divisor of 0 counts as 65536.
- R7: A divisor written while the channel is running leaves the current period unchanged and sets the length of the periods that follow the next reload.
- R8: An accepted setup word stops the counter and holds the output high. The output stays high until a complete new divisor has been written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_ctrl | input | 1 | 1 selects the setup target, 0 selects the data target |
| wr_data | input | 8 | Write byte |
| rate_out | output | 1 | Periodic output, high with a one-clock low pulse each period |

## Verification
The hardest case to create from the ports is a write that arrives while the channel is already counting, where what matters is the phase of that write. It might be a foreign setup word that must not disturb the output, or a new divisor that must not cut the current period short. The stimulus issues these writes a fixed number of clocks after the high-byte capture. It then checks the output on every cycle against a pulse train whose phase is taken from that capture. A second case is a foreign setup word placed between the two halves of a divisor. This shows through the output that the byte pointer survived it.

// File: rtl/rg_pkg.sv
package rg_pkg;

    localparam int BUS_W = 8;
    localparam int CNT_W = 2 * BUS_W;

    localparam logic [1:0] ACC_LO_HI  = 2'b11;
    localparam logic [1:0] MODE_RATE  = 2'b10;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } byte_ptr_e;

    typedef struct packed {
        logic [1:0] chan;
        logic [1:0] access;
        logic [2:0] mode;
        logic       bcd;
    } setup_word_t;

    function automatic logic setup_accepts(setup_word_t w, logic [1:0] own_chan);
        return (w.chan == own_chan) && (w.access == ACC_LO_HI) &&
               (w.mode[1:0] == MODE_RATE) && !w.bcd;
    endfunction

endpackage

// File: rtl/rg_ctrl.sv
module rg_ctrl
    import rg_pkg::*;
#(
    parameter logic [1:0] CHAN_SEL = 2'd0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_ctrl,
    input  logic [BUS_W-1:0] wr_data,
    output logic             halt,
    output logic             commit,
    output logic [CNT_W-1:0] commit_val
);

    setup_word_t sw;
    byte_ptr_e   ptr_q;
    logic        armed_q;
    logic [BUS_W-1:0] lo_q;
    logic        data_wr;

    always_comb begin
        sw         = setup_word_t'(wr_data);
        halt       = wr_en && wr_ctrl && setup_accepts(sw, CHAN_SEL);
        data_wr    = wr_en && !wr_ctrl && armed_q;
        commit     = data_wr && (ptr_q == PTR_HI);
        commit_val = {wr_data, lo_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            ptr_q   <= PTR_LO;
            lo_q    <= '0;
        end else if (halt) begin
            armed_q <= 1'b1;
            ptr_q   <= PTR_LO;
        end else if (data_wr) begin
            if (ptr_q == PTR_LO) begin
                lo_q  <= wr_data;
                ptr_q <= PTR_HI;
            end else begin
                ptr_q <= PTR_LO;
            end
        end
    end

    // R4: a low byte moves the pointer to the high byte
    p_ptr_advance_r4: assert property (@(posedge clk) disable iff (rst)
        data_wr && ptr_q == PTR_LO |=> ptr_q == PTR_HI);

    // R2: an accepted setup word rewinds the pointer and arms data writes
    p_setup_rewind_r2: assert property (@(posedge clk) disable iff (rst)
        halt |=> ptr_q == PTR_LO && armed_q);

    // R3: a rejected setup word leaves the pointer alone
    p_foreign_keep_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_ctrl && !halt |=> ptr_q == $past(ptr_q) && armed_q == $past(armed_q));

    // R1: nothing is committed before a setup word has been taken
    p_no_commit_unarmed_r1: assert property (@(posedge clk) disable iff (rst)
        !armed_q |-> !commit);

endmodule

// File: rtl/rg_down.sv
module rg_down
    import rg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_val,
    output logic             rate_out
);

    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] cnt_q, reload_q, ext_val;
    logic             run_q, at_one;

    always_comb begin
        ext_val  = (commit_val == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, commit_val};
        at_one   = run_q && (cnt_q == EXT_W'(1));
        rate_out = !at_one;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (halt) begin
            run_q    <= 1'b0;
        end else begin
            if (commit)
                reload_q <= ext_val;
            if (!run_q) begin
                if (commit) begin
                    cnt_q <= ext_val;
                    run_q <= 1'b1;
                end
            end else if (at_one) begin
                cnt_q <= commit ? ext_val : reload_q;
            end else begin
                cnt_q <= cnt_q - EXT_W'(1);
            end
        end
    end

    // R5: the low phase lasts one clock
    p_one_clock_low_r5: assert property (@(posedge clk) disable iff (rst)
        !rate_out && !commit && reload_q != EXT_W'(1) |=> rate_out);

    // R5: the captured divisor starts an idle counter
    p_start_r5: assert property (@(posedge clk) disable iff (rst)
        commit && !run_q && !halt |=> run_q && cnt_q == $past(ext_val));

    // R7: the end of a period reloads the stored divisor
    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        at_one && !commit && !halt |=> cnt_q == $past(reload_q));

    // R8: a setup word stops counting and lifts the output
    p_halt_high_r8: assert property (@(posedge clk) disable iff (rst)
        halt |=> !run_q && rate_out);

    // R6: a zero divisor is stored as the full range
    p_zero_full_r6: assert property (@(posedge clk) disable iff (rst)
        commit && !halt && commit_val == '0 |=> reload_q[CNT_W]);

endmodule

// File: rtl/rg_timer.sv
module rg_timer
    import rg_pkg::*;
#(
    parameter logic [1:0] CHAN_SEL = 2'd0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_ctrl,
    input  logic [BUS_W-1:0] wr_data,
    output logic             rate_out
);

    logic             halt;
    logic             commit;
    logic [CNT_W-1:0] commit_val;

    rg_ctrl #(.CHAN_SEL(CHAN_SEL)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_ctrl    (wr_ctrl),
        .wr_data    (wr_data),
        .halt       (halt),
        .commit     (commit),
        .commit_val (commit_val)
    );

    rg_down u_down (
        .clk        (clk),
        .rst        (rst),
        .halt       (halt),
        .commit     (commit),
        .commit_val (commit_val),
        .rate_out   (rate_out)
    );

endmodule

// File: tb/rg_timer_test.sv
module rg_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rate_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rg_timer uut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_ctrl  (wr_ctrl),
        .wr_data  (wr_data),
        .rate_out (rate_out)
    );

    // Called at a negedge; returns at the negedge after the write's edge (j = 0).
    task automatic put(input logic ctl, input logic [7:0] d);
        wr_en = 1'b1;
        wr_ctrl = ctl;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Samples j0 .. j0+cycles-1; low expected at first_low + k*period.
    task automatic observe(input string req, input int j0, input int cycles,
                           input int first_low, input int period);
        int  miss = 0;
        int  mj = 0;
        logic mexp = 1'b1, mact = 1'b1;
        for (int j = j0; j < j0 + cycles; j++) begin
            logic e;
            e = (period > 0 && j >= first_low && ((j - first_low) % period) == 0) ? 1'b0 : 1'b1;
            if (rate_out !== e) begin
                if (miss == 0) begin mj = j; mexp = e; mact = rate_out; end
                miss++;
            end
            @(negedge clk);
        end
        total++;
        if (miss != 0) begin
            bad++;
            $display("FAIL %s: cycle %0d rate_out actual=%b expected=%b (%0d mismatches)",
                     req, mj, mact, mexp, miss);
        end
    endtask

    task automatic t_reset_r1();
        total++;
        if (rate_out !== 1'b1) begin
            bad++;
            $display("FAIL R1: reset output actual=%b expected=1", rate_out);
        end
        put(1'b0, 8'h03);
        put(1'b0, 8'h00);
        observe("R1", 0, 16, 0, 0);
    endtask

    task automatic t_basic_r5();
        put(1'b1, 8'h34);
        put(1'b0, 8'h04);
        put(1'b0, 8'h00);
        observe("R5", 0, 21, 3, 4);
        put(1'b1, 8'h34);
        put(1'b0, 8'h07);
        put(1'b0, 8'h00);
        observe("R5", 0, 30, 6, 7);
    endtask

    task automatic t_alias_r2();
        put(1'b1, 8'h3C);
        put(1'b0, 8'h02);
        put(1'b0, 8'h00);
        observe("R2", 0, 12, 1, 2);
    endtask

    task automatic t_bytes_r4();
        put(1'b1, 8'h34);
        put(1'b0, 8'h05);
        idle(7);
        put(1'b0, 8'h00);
        observe("R4", 0, 20, 4, 5);
        put(1'b1, 8'h34);
        put(1'b0, 8'h03);
        put(1'b0, 8'h01);
        observe("R4", 0, 600, 258, 259);
    endtask

    task automatic t_foreign_r3();
        put(1'b1, 8'h34);
        put(1'b0, 8'h06);
        put(1'b0, 8'h00);
        put(1'b1, 8'h74);   // channel 1
        put(1'b1, 8'h36);   // mode 3
        put(1'b1, 8'h35);   // BCD
        observe("R3", 3, 24, 5, 6);
        put(1'b1, 8'h34);
        put(1'b0, 8'h04);
        put(1'b1, 8'hB4);   // channel 2 between the bytes
        put(1'b0, 8'h00);
        observe("R3", 0, 16, 3, 4);
    endtask

    task automatic t_midrun_r7();
        put(1'b1, 8'h34);
        put(1'b0, 8'h05);
        put(1'b0, 8'h00);
        put(1'b0, 8'h08);
        put(1'b0, 8'h00);
        observe("R7", 2, 26, 4, 8);
    endtask

    task automatic t_halt_r8();
        put(1'b1, 8'h34);
        put(1'b0, 8'h04);
        put(1'b0, 8'h00);
        idle(2);
        put(1'b1, 8'h34);
        observe("R8", 0, 20, 0, 0);
        put(1'b0, 8'h03);
        put(1'b0, 8'h00);
        observe("R8", 0, 15, 2, 3);
    endtask

    task automatic t_zero_r6();
        put(1'b1, 8'h34);
        put(1'b0, 8'h00);
        put(1'b0, 8'h00);
        observe("R6", 0, 65540, 65535, 65536);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_r1();
        t_basic_r5();
        t_alias_r2();
        t_bytes_r4();
        t_foreign_r3();
        t_midrun_r7();
        t_halt_r8();
        t_zero_r6();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule